// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block turns a latched 20-bit byte address and the bus cycle controls into active-low chip selects for a 16-bit memory system. The system has two RAM devices and two ROM devices. Each pair is split into an even byte bank, which carries data bits 7..0, and an odd byte bank, which carries data bits 15..8. RAM fills the bottom 64K of the address space. ROM fills the top 32K, so the reset fetch address FFFF0h falls inside it.

Address bit 0 and an active-low byte-high enable pick the byte lanes. An aligned word access opens both banks of the addressed region. A byte access opens only the bank that matches its lane. I/O cycles never touch memory. A memory access outside both windows raises an unmapped flag instead of a select.

The device-internal address lines are passed through: bits 15..1 for RAM and bits 14..1 for ROM. All outputs are registered, with one cycle of latency.

Top module: `bankDecoder`

## Requirements
- R1: During reset and on the first cycle after it, all four selects are high (inactive) and the unmapped flag is 0.
- R2: A memory access with an address from 00000h to 0FFFFh asserts only RAM selects (low). It never asserts a ROM select.
- R3: A memory access with an address from F8000h to FFFFFh, which includes FFFF0h, asserts only ROM selects.
- R4: Selects are active low, and RAM and ROM selects are never asserted in the same cycle.
- R5: With address bit 0 = 0 and byte-high enable low (a word access), both the even and the odd select of the addressed region are asserted.
- R6: With address bit 0 = 1 and byte-high enable low (an odd-byte access), only the odd select is asserted.
- R7: With address bit 0 = 0 and byte-high enable high (an even-byte access), only the even select is asserted. With address bit 0 = 1 and byte-high enable high, no select is asserted.
- R8: When the memory/IO input is 0 (an I/O cycle), no select is asserted and the unmapped flag stays 0, whatever the address.
- R9: A memory access outside both windows asserts no select and sets the unmapped flag to 1.
- R10: The RAM device address output equals address bits 15..1. The ROM device address output equals address bits 14..1.
- R11: Every output reflects the inputs sampled at the previous rising clock edge. With neither the read strobe nor the write strobe low, no select is asserted and the unmapped flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrIn | input | 20 | Latched byte address |
| bheN | input | 1 | Byte-high enable, active low |
| memSel | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| ramEvenCsN | output | 1 | RAM even-bank select, active low |
| ramOddCsN | output | 1 | RAM odd-bank select, active low |
| romEvenCsN | output | 1 | ROM even-bank select, active low |
| romOddCsN | output | 1 | ROM odd-bank select, active low |
| unmappedAcc | output | 1 | Memory access outside both windows |
| ramDevAddr | output | 15 | Address lines inside a RAM device |
| romDevAddr | output | 14 | Address lines inside a ROM device |

## Verification
Every result, whether a select, the unmapped flag or a device address, is due exactly one rising edge after the inputs are applied. The bench drives on the falling edge. For each stimulus it queues one expected record, and it compares that record 1 ns after the next rising edge. The queue is popped once per edge, so a result that comes a cycle early or late shows up as a mismatch against its neighbour's record. The bench also checks that no record is left in the queue at the end.

// File: rtl/bankDecoderPkg.sv
package bankDecoderPkg;
  // Strobes that the control passes to the datapath each cycle
  typedef struct packed {
    logic cycleOn;
    logic ramHit;
    logic romHit;
    logic evenLane;
    logic oddLane;
    logic unmapped;
  } decStrobe_t;

  localparam int NUM_BANKS = 4;  // index: {region, lane}; region 0 = RAM, lane 0 = even
endpackage

// File: rtl/bankDecoderCtrl.sv
module bankDecoderCtrl
  import bankDecoderPkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int RAM_SPAN_W = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE = 20'h00000,
  parameter int ROM_SPAN_W = 15,
  parameter logic [ADDR_W-1:0] ROM_BASE = 20'hF8000
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              bheN,
  input  logic              memSel,
  input  logic              rdN,
  input  logic              wrN,
  output decStrobe_t        strobe
);
  localparam int RAM_TAG_W = ADDR_W - RAM_SPAN_W;
  localparam int ROM_TAG_W = ADDR_W - ROM_SPAN_W;
  localparam logic [RAM_TAG_W-1:0] RAM_TAG = RAM_BASE[ADDR_W-1:RAM_SPAN_W];
  localparam logic [ROM_TAG_W-1:0] ROM_TAG = ROM_BASE[ADDR_W-1:ROM_SPAN_W];

  logic busCycle, memCycle, inRam, inRom;

  always_comb begin
    busCycle = !rdN || !wrN;
    memCycle = busCycle && memSel;
    inRam    = addrIn[ADDR_W-1:RAM_SPAN_W] == RAM_TAG;
    inRom    = addrIn[ADDR_W-1:ROM_SPAN_W] == ROM_TAG;

    strobe.cycleOn  = memCycle;
    strobe.ramHit   = memCycle && inRam;
    strobe.romHit   = memCycle && inRom && !inRam;
    strobe.evenLane = !addrIn[0];
    strobe.oddLane  = !bheN;
    strobe.unmapped = memCycle && !inRam && !inRom;
  end
endmodule

// File: rtl/bankDecoderPath.sv
module bankDecoderPath
  import bankDecoderPkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int RAM_SPAN_W = 16,
  parameter int ROM_SPAN_W = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  decStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     addrIn,
  output logic [NUM_BANKS-1:0]  csN,
  output logic                  unmappedAcc,
  output logic [RAM_SPAN_W-2:0] ramDevAddr,
  output logic [ROM_SPAN_W-2:0] romDevAddr
);
  logic [NUM_BANKS-1:0] selNext;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    localparam bit IS_ROM = (g / 2) == 1;
    localparam bit IS_ODD = (g % 2) == 1;
    logic regionOn, laneOn;
    assign regionOn = IS_ROM ? strobe.romHit : strobe.ramHit;
    assign laneOn   = IS_ODD ? strobe.oddLane : strobe.evenLane;
    assign selNext[g] = regionOn && laneOn;

    always_ff @(posedge clk) begin
      if (!rstN) csN[g] <= 1'b1;
      else       csN[g] <= !selNext[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unmappedAcc <= 1'b0;
      ramDevAddr  <= '0;
      romDevAddr  <= '0;
    end else begin
      unmappedAcc <= strobe.unmapped;
      ramDevAddr  <= addrIn[RAM_SPAN_W-1:1];
      romDevAddr  <= addrIn[ROM_SPAN_W-1:1];
    end
  end
endmodule

// File: rtl/bankDecoder.sv
module bankDecoder
  import bankDecoderPkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int RAM_SPAN_W = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE = 20'h00000,
  parameter int ROM_SPAN_W = 15,
  parameter logic [ADDR_W-1:0] ROM_BASE = 20'hF8000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     addrIn,
  input  logic                  bheN,
  input  logic                  memSel,
  input  logic                  rdN,
  input  logic                  wrN,
  output logic                  ramEvenCsN,
  output logic                  ramOddCsN,
  output logic                  romEvenCsN,
  output logic                  romOddCsN,
  output logic                  unmappedAcc,
  output logic [RAM_SPAN_W-2:0] ramDevAddr,
  output logic [ROM_SPAN_W-2:0] romDevAddr
);
  decStrobe_t           strobe;
  logic [NUM_BANKS-1:0] csN;

  bankDecoderCtrl #(
    .ADDR_W(ADDR_W), .RAM_SPAN_W(RAM_SPAN_W), .RAM_BASE(RAM_BASE),
    .ROM_SPAN_W(ROM_SPAN_W), .ROM_BASE(ROM_BASE)
  ) uCtrl (
    .addrIn(addrIn), .bheN(bheN), .memSel(memSel),
    .rdN(rdN), .wrN(wrN), .strobe(strobe)
  );

  bankDecoderPath #(
    .ADDR_W(ADDR_W), .RAM_SPAN_W(RAM_SPAN_W), .ROM_SPAN_W(ROM_SPAN_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn),
    .csN(csN), .unmappedAcc(unmappedAcc),
    .ramDevAddr(ramDevAddr), .romDevAddr(romDevAddr)
  );

  assign ramEvenCsN = csN[0];
  assign ramOddCsN  = csN[1];
  assign romEvenCsN = csN[2];
  assign romOddCsN  = csN[3];
endmodule

// File: rtl/bankDecoderChk.sv
module bankDecoderChk (
  input logic        clk,
  input logic        rstN,
  input logic [19:0] addrIn,
  input logic        bheN,
  input logic        memSel,
  input logic        rdN,
  input logic        wrN,
  input logic        ramEvenCsN,
  input logic        ramOddCsN,
  input logic        romEvenCsN,
  input logic        romOddCsN,
  input logic        unmappedAcc
);
  logic memOn;
  assign memOn = memSel && (!rdN || !wrN);

  assert_one_region_R4: assert property (@(posedge clk) disable iff (!rstN)
    !((!ramEvenCsN || !ramOddCsN) && (!romEvenCsN || !romOddCsN)));

  assert_ram_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memOn && addrIn[19:16] == 4'h0 && !addrIn[0] && !bheN)
    |=> (!ramEvenCsN && !ramOddCsN && romEvenCsN && romOddCsN));

  assert_odd_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addrIn[0] && !bheN) |=> (ramEvenCsN && romEvenCsN));

  assert_even_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    bheN |=> (ramOddCsN && romOddCsN));

  assert_io_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !memSel |=> (ramEvenCsN && ramOddCsN && romEvenCsN && romOddCsN && !unmappedAcc));

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    unmappedAcc |-> (ramEvenCsN && ramOddCsN && romEvenCsN && romOddCsN));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdN && wrN) |=> (ramEvenCsN && ramOddCsN && romEvenCsN && romOddCsN && !unmappedAcc));

  assert_rom_reset_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memOn && addrIn == 20'hFFFF0 && !bheN) |=> (!romEvenCsN && !romOddCsN));
endmodule

bind bankDecoder bankDecoderChk uChk (
  .clk(clk), .rstN(rstN), .addrIn(addrIn), .bheN(bheN), .memSel(memSel),
  .rdN(rdN), .wrN(wrN), .ramEvenCsN(ramEvenCsN), .ramOddCsN(ramOddCsN),
  .romEvenCsN(romEvenCsN), .romOddCsN(romOddCsN), .unmappedAcc(unmappedAcc)
);

// File: tb/bankDecoder_test.sv
`timescale 1ns/1ps
module bankDecoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] addrIn = '0;
  logic        bheN = 1'b1, memSel = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic        ramEvenCsN, ramOddCsN, romEvenCsN, romOddCsN, unmappedAcc;
  logic [14:0] ramDevAddr;
  logic [13:0] romDevAddr;

  int compared = 0;
  int mismatched = 0;

  typedef struct packed {
    logic [3:0]  csN;  // {ramEven, ramOdd, romEven, romOdd}
    logic        unm;
    logic [14:0] ramA;
    logic [13:0] romA;
  } expect_t;

  expect_t    expQ[$];
  string      tagQ[$];
  logic       doneFlag = 1'b0;

  always #2 clk = ~clk;

  bankDecoder uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .bheN(bheN), .memSel(memSel),
    .rdN(rdN), .wrN(wrN), .ramEvenCsN(ramEvenCsN), .ramOddCsN(ramOddCsN),
    .romEvenCsN(romEvenCsN), .romOddCsN(romOddCsN), .unmappedAcc(unmappedAcc),
    .ramDevAddr(ramDevAddr), .romDevAddr(romDevAddr)
  );

  function automatic expect_t model(logic [19:0] a, logic bhe, logic mem, logic rd, logic wr);
    expect_t e;
    logic on, ram, rom, ev, od;
    on  = mem && (!rd || !wr);
    ram = on && a <= 20'h0FFFF;
    rom = on && a >= 20'hF8000;
    ev  = !a[0];
    od  = !bhe;
    e.csN  = {!(ram && ev), !(ram && od), !(rom && ev), !(rom && od)};
    e.unm  = on && !ram && !rom;
    e.ramA = a[15:1];
    e.romA = a[14:1];
    return e;
  endfunction

  function automatic expect_t observed();
    expect_t o;
    o.csN  = {ramEvenCsN, ramOddCsN, romEvenCsN, romOddCsN};
    o.unm  = unmappedAcc;
    o.ramA = ramDevAddr;
    o.romA = romDevAddr;
    return o;
  endfunction

  task automatic drive(string tag, logic [19:0] a, logic bhe, logic mem, logic rd, logic wr);
    @(negedge clk);
    addrIn = a; bheN = bhe; memSel = mem; rdN = rd; wrN = wr;
    expQ.push_back(model(a, bhe, mem, rd, wr));
    tagQ.push_back(tag);
  endtask

  // monitor: each result is due one rising edge after its stimulus
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expect_t e, o;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      o = observed();
      compared++;
      if (o !== e) begin
        mismatched++;
        $display("FAIL %s: got cs=%b unm=%b ram=%h rom=%h exp cs=%b unm=%b ram=%h rom=%h",
                 t, o.csN, o.unm, o.ramA, o.romA, e.csN, e.unm, e.ramA, e.romA);
      end
    end
  end

  initial begin
    #(4 * 50000);
    if (!doneFlag) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got hung exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;  // R1 reset state
    if ({ramEvenCsN, ramOddCsN, romEvenCsN, romOddCsN, unmappedAcc} !== 5'b11110) begin
      mismatched++;
      $display("FAIL R1: got %b exp 11110",
               {ramEvenCsN, ramOddCsN, romEvenCsN, romOddCsN, unmappedAcc});
    end
    @(negedge clk); rstN = 1'b1;
    drive("R1_R11 idle after reset", 20'h00000, 1'b0, 1'b1, 1'b1, 1'b1);
    drive("R2_R5 ram word read",     20'h01234, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R6 ram odd byte",         20'h0ABCD, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R7 ram even byte write",  20'h05556, 1'b1, 1'b1, 1'b1, 1'b0);
    drive("R7 no lane",              20'h00021, 1'b1, 1'b1, 1'b0, 1'b1);
    drive("R3_R5 rom reset vector",  20'hFFFF0, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R3_R6 rom odd low edge",  20'hF8001, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R3_R7 rom even byte",     20'hFC002, 1'b1, 1'b1, 1'b0, 1'b1);
    drive("R3 rom top",              20'hFFFFE, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R8 io cycle",             20'h00010, 1'b0, 1'b0, 1'b0, 1'b1);
    drive("R8 io high address",      20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive("R9 unmapped middle",      20'h50000, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R2_R6 ram top edge",      20'h0FFFF, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R9 just above ram",       20'h10000, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R9 just below rom",       20'hF7FFF, 1'b0, 1'b1, 1'b1, 1'b0);
    drive("R11 idle in rom window",  20'hF8000, 1'b0, 1'b1, 1'b1, 1'b1);
    drive("R4_R5 rom base word",     20'hF8000, 1'b0, 1'b1, 1'b0, 1'b1);
    drive("R4_R5 back to ram",       20'h00000, 1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 24; i++) begin
      logic [19:0] a;
      a = {i[3:0], 16'h0} ^ (20'h1357B * i);
      drive("R10 address sweep", a, i[1], 1'b1, i[0], !i[0]);
    end
    drive("R11 final idle", 20'h00000, 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R11: got %0d pending exp 0", expQ.size());
    end
    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule